// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block switches byte-wide PCM channels between serial time-division lines. Eight input lines and eight output lines each carry 32 eight-bit channels per frame, one bit per clock, most significant bit first. Every received channel is stored in a data memory that holds two frames and swaps halves each frame. For each output channel, a connection memory entry chooses what leaves in that slot. The choices are any of the 256 input channels, or a byte written by the processor. The entry also sets the delay mode and whether the slot drives at all.

Each output channel has two delay modes. Variable delay sends the newest byte already received for the source. Constant delay sends every source from the previous frame, so a group of channels that arrive together in one frame also leave together, in order, in the next frame. A processor port with a 6-bit address, separate write and read data buses, a chip select and a write enable programs a control register and the connection memory, and reads back the data memory. Processor accesses use their own memory ports, so they never stall or shift the serial timing.

Top module: `tsi_switch`

## Requirements
- R1: The cycle in which `frame_n` is low is bit slot 0 of a frame, which is the MSB of channel 0. Channel c occupies bit slots 8c to 8c+7 on both inputs and outputs, MSB first, and the slot counter wraps after slot 255.
- R2: An enabled variable-delay output channel c in frame F carries its source byte from frame F if c is not 0 and the source channel number is below c. Otherwise it carries the source byte from frame F-1.
- R3: An enabled constant-delay output channel in frame F always carries its source byte from frame F-1, whatever its own or the source's channel number.
- R4: In message mode an enabled output channel sends the 8-bit low connection entry itself, MSB first, in place of switched data.
- R5: A channel whose enable bit is clear holds its `soe` bit low and its `sout` bit high for the whole slot. An enabled channel holds its `soe` bit high for all eight bits.
- R6: While `ode` is low, every `soe` bit is low and every `sout` bit is high.
- R7: Several output channels may name the same source in the same frame, and each one receives that byte.
- R8: With address bit 5 = 0, the port reaches the control register. Bits [4:3] select the memory (00 data, 01 low connection, 10 high connection, 11 none) and bits [2:0] select the line. Bits [7:5] are not stored and read as 0.
- R9: With address bit 5 = 1, address bits [4:0] give the channel. The low connection entry is {source line [7:5], source channel [4:0]} or the message byte. The high entry holds enable (bit 2), message (bit 1) and constant delay (bit 0), and its bits [7:3] read 0. Select 11 reads 0 and drops writes.
- R10: Data-memory reads return the byte from the most recently completed frame for the selected line and channel. Processor writes with the data memory selected are dropped.
- R11: After reset the control register reads 0, every high connection entry is 0, and all outputs are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame start, marks bit slot 0 |
| ode | input | 1 | Global output drive enable |
| sin | input | 8 | Serial input lines |
| sout | output | 8 | Serial output data lines |
| soe | output | 8 | Per-line output drive enables |
| cpu_cs | input | 1 | Processor chip select |
| cpu_we | input | 1 | Processor write enable |
| cpu_addr | input | 6 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data, valid while selected |

## Verification
The bench uses the default parameters: eight lines, 32 channels per line and 8-bit channels. These widths mean every line index and the 31-to-0 channel wrap are reached. Channel 0 is loaded during the last slot of the previous frame, and the bypass path covers a source that finishes in the same cycle. Five continuous frames cycle the data-memory halves through more than two swaps. The constant-delay and variable-delay frame choices can therefore be checked on both sides of the channel-number comparison.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef enum logic [1:0] {
    MSEL_DATA = 2'b00,
    MSEL_CLO  = 2'b01,
    MSEL_CHI  = 2'b10,
    MSEL_NONE = 2'b11
  } msel_e;

  typedef struct packed {
    logic en;
    logic msg;
    logic cdly;
  } cm_hi_t;
endpackage

// File: rtl/tsi_frame_ctr.sv
module tsi_frame_ctr #(
  parameter int NCH = 32,
  parameter int BW  = 8,
  localparam int CNTW = $clog2(NCH * BW),
  localparam int BITW = $clog2(BW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_n,
  output logic [CNTW-1:0] slot,
  output logic            par,
  output logic            byte_end
);
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            par_q, par_d;
  logic            last_slot;

  always_comb begin
    slot      = frame_n ? cnt_q : '0;
    last_slot = (slot == CNTW'(NCH * BW - 1));
    cnt_d     = last_slot ? '0 : slot + 1'b1;
    par_d     = last_slot ? ~par_q : par_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      par_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      par_q <= par_d;
    end
  end

  assign par      = par_q;
  assign byte_end = &slot[BITW-1:0];
endmodule

// File: rtl/tsi_rx_deser.sv
module tsi_rx_deser #(
  parameter int NSTR = 8,
  parameter int BW   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSTR-1:0]          sin,
  output logic [NSTR-1:0][BW-1:0]  rx_byte
);
  for (genvar i = 0; i < NSTR; i++) begin : g_line
    logic [BW-2:0] sh_q, sh_d;
    always_comb sh_d = {sh_q[BW-3:0], sin[i]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end
    assign rx_byte[i] = {sh_q, sin[i]};
  end
endmodule

// File: rtl/tsi_tx_ser.sv
module tsi_tx_ser #(
  parameter int NSTR = 8,
  parameter int BW   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [NSTR-1:0][BW-1:0] ld_byte,
  input  logic [NSTR-1:0]         ld_en,
  input  logic                    ode,
  output logic [NSTR-1:0]         sout,
  output logic [NSTR-1:0]         soe
);
  for (genvar i = 0; i < NSTR; i++) begin : g_line
    logic [BW-1:0] sh_q, sh_d;
    logic          oe_q, oe_d;
    always_comb begin
      if (load) begin
        sh_d = ld_byte[i];
        oe_d = ld_en[i];
      end else begin
        sh_d = {sh_q[BW-2:0], 1'b1};
        oe_d = oe_q;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q <= '1;
        oe_q <= 1'b0;
      end else begin
        sh_q <= sh_d;
        oe_q <= oe_d;
      end
    end
    assign soe[i]  = oe_q & ode;
    assign sout[i] = soe[i] ? sh_q[BW-1] : 1'b1;
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int NSTR = 8,
  parameter int NCH  = 32,
  parameter int BW   = 8,
  localparam int SW   = $clog2(NSTR),
  localparam int CW   = $clog2(NCH),
  localparam int CNTW = $clog2(NCH * BW),
  localparam int BITW = $clog2(BW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_n,
  input  logic            ode,
  input  logic [NSTR-1:0] sin,
  output logic [NSTR-1:0] sout,
  output logic [NSTR-1:0] soe,
  input  logic            cpu_cs,
  input  logic            cpu_we,
  input  logic [CW:0]     cpu_addr,
  input  logic [BW-1:0]   cpu_wdata,
  output logic [BW-1:0]   cpu_rdata
);
  localparam int CTLW = SW + 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  // frame timing
  logic [CNTW-1:0] slot;
  logic            par, byte_end;
  logic [CW-1:0]   cur_ch, nxt_ch;
  logic            last_ch;

  tsi_frame_ctr #(.NCH(NCH), .BW(BW)) u_ctr (
    .clk(clk), .rst_n(rst_n_s), .frame_n(frame_n),
    .slot(slot), .par(par), .byte_end(byte_end)
  );

  assign cur_ch  = slot[CNTW-1:BITW];
  assign last_ch = (cur_ch == CW'(NCH - 1));
  assign nxt_ch  = last_ch ? '0 : cur_ch + 1'b1;

  // receive path and two-frame data memory
  logic [NSTR-1:0][BW-1:0] rx_byte;
  logic [BW-1:0]           dmem [2][NSTR][NCH];

  tsi_rx_deser #(.NSTR(NSTR), .BW(BW)) u_rx (
    .clk(clk), .rst_n(rst_n_s), .sin(sin), .rx_byte(rx_byte)
  );

  always_ff @(posedge clk) begin
    if (byte_end) begin
      for (int s = 0; s < NSTR; s++) dmem[par][s][cur_ch] <= rx_byte[s];
    end
  end

  // control register and processor writes
  logic [CTLW-1:0] ctrl_q, ctrl_d;
  msel_e           msel;
  logic [SW-1:0]   sel_str;
  logic [CW-1:0]   cpu_ch;
  logic            mem_wr, lo_we, hi_we;

  assign msel    = msel_e'(ctrl_q[CTLW-1:SW]);
  assign sel_str = ctrl_q[SW-1:0];
  assign cpu_ch  = cpu_addr[CW-1:0];
  assign mem_wr  = cpu_cs && cpu_we && cpu_addr[CW];
  assign lo_we   = mem_wr && (msel == MSEL_CLO);
  assign hi_we   = mem_wr && (msel == MSEL_CHI);

  always_comb begin
    ctrl_d = ctrl_q;
    if (cpu_cs && cpu_we && !cpu_addr[CW]) ctrl_d = cpu_wdata[CTLW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) ctrl_q <= '0;
    else          ctrl_q <= ctrl_d;
  end

  // connection memory
  logic [BW-1:0] cm_lo [NSTR][NCH];
  cm_hi_t        cm_hi [NSTR][NCH];

  always_ff @(posedge clk) begin
    if (lo_we) cm_lo[sel_str][cpu_ch] <= cpu_wdata;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      for (int s = 0; s < NSTR; s++)
        for (int c = 0; c < NCH; c++) cm_hi[s][c] <= '0;
    end else if (hi_we) begin
      cm_hi[sel_str][cpu_ch] <= cm_hi_t'(cpu_wdata[2:0]);
    end
  end

  // processor read mux
  always_comb begin
    cpu_rdata = '0;
    if (cpu_cs) begin
      if (!cpu_addr[CW]) begin
        cpu_rdata[CTLW-1:0] = ctrl_q;
      end else begin
        unique case (msel)
          MSEL_DATA: cpu_rdata = dmem[~par][sel_str][cpu_ch];
          MSEL_CLO:  cpu_rdata = cm_lo[sel_str][cpu_ch];
          MSEL_CHI:  cpu_rdata[2:0] = cm_hi[sel_str][cpu_ch];
          default:   cpu_rdata = '0;
        endcase
      end
    end
  end

  // source selection for the channel loaded at the end of this byte
  logic [NSTR-1:0][BW-1:0] ld_byte;
  logic [NSTR-1:0]         ld_en;

  for (genvar o = 0; o < NSTR; o++) begin : g_sel
    logic [BW-1:0] ent_lo;
    cm_hi_t        ent_hi;
    logic [SW-1:0] src_s;
    logic [CW-1:0] src_c;
    logic          use_cur;
    always_comb begin
      ent_lo  = cm_lo[o][nxt_ch];
      ent_hi  = cm_hi[o][nxt_ch];
      src_s   = ent_lo[CW+SW-1:CW];
      src_c   = ent_lo[CW-1:0];
      use_cur = last_ch || (!ent_hi.cdly && (src_c <= cur_ch));
      if (ent_hi.msg)                        ld_byte[o] = ent_lo;
      else if (use_cur && (src_c == cur_ch)) ld_byte[o] = rx_byte[src_s];
      else if (use_cur)                      ld_byte[o] = dmem[par][src_s][src_c];
      else                                   ld_byte[o] = dmem[~par][src_s][src_c];
      ld_en[o] = ent_hi.en;
    end
  end

  tsi_tx_ser #(.NSTR(NSTR), .BW(BW)) u_tx (
    .clk(clk), .rst_n(rst_n_s), .load(byte_end),
    .ld_byte(ld_byte), .ld_en(ld_en), .ode(ode),
    .sout(sout), .soe(soe)
  );
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int NSTR = 8,
  parameter int CNTW = 8,
  parameter int BITW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_n,
  input logic            ode,
  input logic [NSTR-1:0] sout,
  input logic [NSTR-1:0] soe,
  input logic [CNTW-1:0] slot
);
  // R6: the global enable gates every line
  a_r6_ode_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !ode |-> (soe == '0));

  // R5: an undriven line idles high
  a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    &(sout | soe));

  // R5: per-channel enable changes only at a channel boundary
  a_r5_oe_per_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (ode && (slot[BITW-1:0] != '1)) |=> (!ode || $stable(soe)));

  // R1: the frame pulse realigns the bit-slot counter
  a_r1_frame_align: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> (!frame_n || (slot == CNTW'(1))));
endmodule

bind tsi_switch tsi_switch_chk #(.NSTR(NSTR), .CNTW(CNTW), .BITW(BITW)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .frame_n(frame_n), .ode(ode),
  .sout(sout), .soe(soe), .slot(slot)
);

// File: tb/tsi_switch_bench.sv
module tsi_switch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  localparam int K_SAME = 0, K_PREV = 1, K_MSG = 2, K_OFF = 3;
  localparam int OFF_FRAME = 3;
  localparam int NFRAMES = 5;

  // {kind[20:19], out line[18:16], out ch[15:11], high[10:8], low[7:0]}
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 3'd0, 5'd5,  3'b100, 8'h43},  // R2 variable, src ch 3 < 5
    {2'd1, 3'd1, 5'd2,  3'b100, 8'hF4},  // R2 variable, src ch 20 > 2
    {2'd1, 3'd2, 5'd0,  3'b100, 8'h00},  // R2 variable, out ch 0
    {2'd1, 3'd3, 5'd10, 3'b101, 8'h81},  // R3 constant
    {2'd1, 3'd4, 5'd31, 3'b101, 8'hBF},  // R3 constant, ch 31
    {2'd2, 3'd5, 5'd7,  3'b110, 8'hC6},  // R4 message, R1 bit order
    {2'd3, 3'd6, 5'd9,  3'b001, 8'h21},  // R5 disabled
    {2'd0, 3'd7, 5'd31, 3'b100, 8'hFE},  // R2 variable, src 30 < 31
    {2'd1, 3'd0, 5'd31, 3'b100, 8'h1F},  // R2 variable, src == out ch
    {2'd0, 3'd1, 5'd1,  3'b100, 8'h60},  // R2 variable, src 0 < 1
    {2'd0, 3'd2, 5'd5,  3'b100, 8'h43},  // R7 same source as first row
    {2'd1, 3'd6, 5'd1,  3'b101, 8'hC0}   // R3 constant, src 0 < 1
  };

  logic       clk = 1'b0;
  logic       rst_n, frame_n, ode;
  logic [7:0] sin, sout, soe;
  logic       cpu_cs, cpu_we;
  logic [5:0] cpu_addr;
  logic [7:0] cpu_wdata, cpu_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] cap_b   [8][32];
  logic       cap_all [8][32];
  logic       cap_any [8][32];
  logic       frame_any;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tsi_switch u_tsi_switch (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ode(ode),
    .sin(sin), .sout(sout), .soe(soe),
    .cpu_cs(cpu_cs), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  function automatic logic [7:0] pat(input int f, input int s, input int c);
    return 8'((f * 37 + s * 32 + c * 3 + 11) & 255);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic cpu_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_cs = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_cs = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_cs = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    #1 d = cpu_rdata;
    cpu_cs = 1'b0;
  endtask

  task automatic eval_frame(input int f);
    if (f == OFF_FRAME) begin
      check("R6", "any output enable while ode low", 32'(frame_any), 32'd0);
      check("R6", "line 0 ch 5 level while ode low", 32'(cap_b[0][5]), 32'hFF);
    end else if (f >= 2) begin
      for (int v = 0; v < NV; v++) begin
        int kind, o, c, ss, sc;
        logic [7:0] lo, exp;
        string req;
        kind = int'(VEC[v][20:19]);
        o    = int'(VEC[v][18:16]);
        c    = int'(VEC[v][15:11]);
        lo   = VEC[v][7:0];
        ss   = int'(lo[7:5]);
        sc   = int'(lo[4:0]);
        req  = (v == 10) ? "R7" : (kind == K_MSG) ? "R1/R4" : (kind == K_OFF) ? "R5" :
               (VEC[v][8] ? "R3" : "R2");
        case (kind)
          K_SAME:  exp = pat(f, ss, sc);
          K_PREV:  exp = pat(f - 1, ss, sc);
          K_MSG:   exp = lo;
          default: exp = 8'hFF;
        endcase
        if (kind == K_OFF)
          check(req, $sformatf("row %0d enable seen", v), 32'(cap_any[o][c]), 32'd0);
        else
          check(req, $sformatf("row %0d enable held", v), 32'(cap_all[o][c]), 32'd1);
        check(req, $sformatf("row %0d frame %0d byte", v, f), 32'(cap_b[o][c]), 32'(exp));
      end
      check("R11", "unprogrammed line 4 ch 0 enable", 32'(cap_any[4][0]), 32'd0);
    end
  endtask

  task automatic stream();
    for (int f = 0; f < NFRAMES; f++) begin
      for (int t = 0; t < 256; t++) begin
        int ch, bi, nf;
        @(negedge clk);
        ch = t / 8;
        bi = t % 8;
        if (t == 0) frame_any = 1'b0;
        for (int o = 0; o < 8; o++) begin
          if (bi == 0) begin
            cap_b[o][ch] = 8'h00; cap_all[o][ch] = 1'b1; cap_any[o][ch] = 1'b0;
          end
          cap_b[o][ch]   = {cap_b[o][ch][6:0], sout[o]};
          cap_all[o][ch] = cap_all[o][ch] & soe[o];
          cap_any[o][ch] = cap_any[o][ch] | soe[o];
        end
        frame_any = frame_any | (|soe);
        frame_n = (t != 0);
        for (int s = 0; s < 8; s++) sin[s] = pat(f, s, ch)[7 - bi];
        nf  = (t == 255) ? f + 1 : f;
        ode = (nf != OFF_FRAME);
      end
      eval_frame(f);
    end
    @(negedge clk);
    sin = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; frame_n = 1'b1; ode = 1'b1; sin = 8'h00;
    cpu_cs = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check("R11", "enables after reset", 32'(soe), 32'h00);
    check("R5", "idle level after reset", 32'(sout), 32'hFF);
    cpu_rd(6'h00, rd);
    check("R11", "control register after reset", 32'(rd), 32'h00);
    cpu_wr(6'h00, {3'b000, 2'b10, 3'd3});
    cpu_rd({1'b1, 5'd10}, rd);
    check("R11", "high entry line 3 ch 10 after reset", 32'(rd), 32'h00);

    // control register width
    cpu_wr(6'h00, 8'hFF);
    cpu_rd(6'h00, rd);
    check("R8", "control register keeps bits 4:0", 32'(rd), 32'h1F);

    // program the connection rows
    for (int v = 0; v < NV; v++) begin
      logic [2:0] o;
      logic [4:0] c;
      o = VEC[v][18:16];
      c = VEC[v][15:11];
      cpu_wr(6'h00, {3'b000, 2'b01, o});
      cpu_wr({1'b1, c}, VEC[v][7:0]);
      cpu_wr(6'h00, {3'b000, 2'b10, o});
      cpu_wr({1'b1, c}, {5'b00000, VEC[v][10:8]});
    end
    cpu_rd({1'b1, 5'd1}, rd);
    check("R9", "high entry readback line 6 ch 1", 32'(rd), 32'h05);
    cpu_wr(6'h00, {3'b000, 2'b01, 3'd5});
    cpu_rd({1'b1, 5'd7}, rd);
    check("R9", "low entry readback line 5 ch 7", 32'(rd), 32'hC6);
    cpu_wr(6'h00, {3'b000, 2'b11, 3'd5});
    cpu_wr({1'b1, 5'd7}, 8'h3C);
    cpu_rd({1'b1, 5'd7}, rd);
    check("R9", "select 11 reads zero", 32'(rd), 32'h00);
    cpu_wr(6'h00, {3'b000, 2'b01, 3'd5});
    cpu_rd({1'b1, 5'd7}, rd);
    check("R9", "select 11 write dropped", 32'(rd), 32'hC6);

    // switching over continuous frames
    stream();

    // data memory readback during the frame after the last streamed one
    cpu_wr(6'h00, {3'b000, 2'b00, 3'd6});
    cpu_rd({1'b1, 5'd12}, rd);
    check("R10", "data line 6 ch 12", 32'(rd), 32'(pat(NFRAMES - 1, 6, 12)));
    cpu_wr({1'b1, 5'd12}, 8'h00);
    cpu_rd({1'b1, 5'd12}, rd);
    check("R10", "data write dropped", 32'(rd), 32'(pat(NFRAMES - 1, 6, 12)));
    cpu_rd({1'b1, 5'd0}, rd);
    check("R10", "data line 6 ch 0", 32'(rd), 32'(pat(NFRAMES - 1, 6, 0)));

    summary();
    $finish;
  end
endmodule